// File: doc/BRIEF.md
# Saturating Event Counter with Update-Clear Snapshot

This block counts single-cycle event strobes, such as detected bit errors or framing violations, in a live counter. Software reads the count from a separate holding register. A level request from outside marks the end of an interval. On its rising edge the block copies the live count into the holding register and restarts the live count. The holding register then keeps that value steady for the whole next interval, so software can read it at its own pace.

The counter stops at its all-ones value and never rolls over. Its width is a parameter, 16 bits by default, and is meant to be sized to hold a full interval of events at the peak event rate. If an event arrives in the same cycle as the restart, it is kept by loading one instead of zero.

Three status outputs go with the count:
- A live flag that is high while the count is nonzero.
- A sticky flag that marks the first event counted from zero.
- A sticky flag that marks every counted event.

Each sticky flag is cleared by writing a one to its clear strobe. A set in the same cycle beats the clear.

Top module: `pm_event_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `hold_o` becomes 0 and `nz_o`, `first_stk_o` and `evt_stk_o` become 0 at that edge.
- R2: Each cycle with `evt_i` high, no update-clear, and a live count below all-ones adds exactly one to the live count.
- R3: The live count stops at 2^CNT_W-1 (65535 by default) and does not wrap while events continue.
- R4: An update-clear happens only in the cycle where `upd_req_i` is first sampled high after being low. That cycle copies the live count (excluding that cycle's event) into `hold_o`, visible after the edge. `hold_o` keeps its value until the next such rising edge, even while `upd_req_i` stays high.
- R5: An event in the update-clear cycle leaves the live count at 1 instead of 0.
- R6: After every edge, `nz_o` is high exactly when the live count is nonzero.
- R7: `first_stk_o` (clear strobe bit 0 of `sts_clr_i`) sets when an event is counted while the live count is zero or in an update-clear cycle. Events counted on a nonzero count do not set it.
- R8: `evt_stk_o` (clear strobe bit 1 of `sts_clr_i`) sets on every event that changes the live count. An event arriving while the count is saturated, outside an update-clear, does not set it.
- R9: Writing a one to a bit of `sts_clr_i` clears the matching sticky flag at the next edge, and a zero bit leaves it alone. If that flag's set condition occurs in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Event strobe, one event per high cycle |
| upd_req_i | input | 1 | Update-clear request level; acts on its rising edge |
| sts_clr_i | input | 2 | Write-one-to-clear strobes: bit 0 first-count flag, bit 1 per-event flag |
| hold_o | output | CNT_W | Holding register read by software |
| nz_o | output | 1 | Live count is nonzero |
| first_stk_o | output | 1 | Sticky: counting started from zero |
| evt_stk_o | output | 1 | Sticky: an event was counted |

## Verification
The properties assume that `evt_i`, `upd_req_i` and `sts_clr_i` are synchronous to `clk` and stable around each rising edge. They also assume that `rst` is asserted at the first edge, so the edge detector starts from a known low level. The stimulus changes every input only on the falling edge and holds reset for several cycles before releasing it. It keeps `upd_req_i` low through reset, so the first update-clear is always a real low-to-high transition. One long run of back-to-back events drives the count into saturation, so the no-wrap and no-set-at-saturation properties see their antecedents.

// File: rtl/pm_cnt_pkg.sv
package pm_cnt_pkg;
  localparam int STK_N = 2;

  typedef enum logic [0:0] {
    STK_FIRST = 1'b0,
    STK_EVENT = 1'b1
  } stk_idx_e;
endpackage

// File: rtl/pm_edge_detect.sv
module pm_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/pm_sat_counter.sv
module pm_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hold_o,
  output logic             nz_o,
  output logic             counted_o,
  output logic             from_zero_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, hold_q;
  logic             nz_q, at_max, is_zero;

  assign at_max  = (cnt_q == CNT_MAX);
  assign is_zero = (cnt_q == '0);

  always_comb begin
    if (clr_i)                 cnt_d = evt_i ? CNT_ONE : '0;
    else if (evt_i && !at_max) cnt_d = cnt_q + CNT_ONE;
    else                       cnt_d = cnt_q;
  end

  assign counted_o   = evt_i & (clr_i | ~at_max);
  assign from_zero_o = evt_i & (clr_i | is_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= '0;
      nz_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      nz_q  <= (cnt_d != '0);
      if (clr_i) hold_q <= cnt_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;
  assign nz_o   = nz_q;
endmodule

// File: rtl/pm_sticky_bits.sv
module pm_sticky_bits #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic b_q;
    always_ff @(posedge clk) begin
      if (rst)           b_q <= 1'b0;
      else if (set_i[g]) b_q <= 1'b1;
      else if (clr_i[g]) b_q <= 1'b0;
    end
    assign q_o[g] = b_q;
  end
endmodule

// File: rtl/pm_event_counter.sv
module pm_event_counter
  import pm_cnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  logic             upd_req_i,
  input  logic [STK_N-1:0] sts_clr_i,
  output logic [CNT_W-1:0] hold_o,
  output logic             nz_o,
  output logic             first_stk_o,
  output logic             evt_stk_o
);
  logic             upd_rise;
  logic [CNT_W-1:0] live_cnt;
  logic             counted, from_zero;
  logic [STK_N-1:0] stk_set, stk_q;

  pm_edge_detect u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (upd_req_i),
    .rise_o (upd_rise)
  );

  pm_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .clr_i       (upd_rise),
    .cnt_o       (live_cnt),
    .hold_o      (hold_o),
    .nz_o        (nz_o),
    .counted_o   (counted),
    .from_zero_o (from_zero)
  );

  always_comb begin
    stk_set            = '0;
    stk_set[STK_FIRST] = from_zero;
    stk_set[STK_EVENT] = counted;
  end

  pm_sticky_bits #(.N(STK_N)) u_stk (
    .clk   (clk),
    .rst   (rst),
    .set_i (stk_set),
    .clr_i (sts_clr_i),
    .q_o   (stk_q)
  );

  assign first_stk_o = stk_q[STK_FIRST];
  assign evt_stk_o   = stk_q[STK_EVENT];
endmodule

// File: rtl/pm_event_counter_chk.sv
module pm_event_counter_chk
  import pm_cnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_i,
  input logic             upd_rise,
  input logic [CNT_W-1:0] live_cnt,
  input logic [CNT_W-1:0] hold_o,
  input logic             nz_o,
  input logic [STK_N-1:0] stk_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (hold_o == '0 && !nz_o && stk_q == '0));

  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    (evt_i && !upd_rise && live_cnt != CNT_MAX) |=> (live_cnt - $past(live_cnt)) == CNT_ONE);

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (live_cnt == CNT_MAX && !upd_rise) |=> live_cnt == CNT_MAX);

  a_r4_copy: assert property (@(posedge clk) disable iff (rst)
    upd_rise |=> hold_o == $past(live_cnt));

  a_r4_hold_steady: assert property (@(posedge clk) disable iff (rst)
    !upd_rise |=> $stable(hold_o));

  a_r5_keep_event: assert property (@(posedge clk) disable iff (rst)
    (upd_rise && evt_i) |=> live_cnt == CNT_ONE);

  a_r6_nonzero: assert property (@(posedge clk) disable iff (rst)
    nz_o == (live_cnt != '0));

  a_r7_first_set: assert property (@(posedge clk) disable iff (rst)
    (evt_i && (upd_rise || live_cnt == '0)) |=> stk_q[STK_FIRST]);

  a_r8_event_set: assert property (@(posedge clk) disable iff (rst)
    (evt_i && (upd_rise || live_cnt != CNT_MAX)) |=> stk_q[STK_EVENT]);
endmodule

bind pm_event_counter pm_event_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .evt_i    (evt_i),
  .upd_rise (upd_rise),
  .live_cnt (live_cnt),
  .hold_o   (hold_o),
  .nz_o     (nz_o),
  .stk_q    (stk_q)
);

// File: tb/sim_pm_event_counter.sv
`timescale 1ns/1ps
module sim_pm_event_counter;
  localparam int CNT_W = 16;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             evt = 1'b0;
  logic             upd = 1'b0;
  logic [1:0]       sclr = 2'b00;
  logic [CNT_W-1:0] hold;
  logic             nz, fst, est;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  int m_cnt = 0, m_hold = 0;
  bit m_nz = 0, m_fst = 0, m_est = 0, m_prev = 0;

  always #5 clk = ~clk;

  pm_event_counter #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .evt_i(evt), .upd_req_i(upd), .sts_clr_i(sclr),
    .hold_o(hold), .nz_o(nz), .first_stk_o(fst), .evt_stk_o(est)
  );

  // behavioural reference model
  always @(posedge clk) begin
    bit rise, s_f, s_e;
    if (rst) begin
      m_cnt = 0; m_hold = 0; m_nz = 0; m_fst = 0; m_est = 0; m_prev = 0;
    end else begin
      rise = upd && !m_prev;
      m_prev = upd;
      s_f = 0; s_e = 0;
      if (rise) begin
        m_hold = m_cnt;
        if (evt) begin m_cnt = 1; s_f = 1; s_e = 1; end
        else m_cnt = 0;
      end else if (evt && m_cnt < MAXV) begin
        if (m_cnt == 0) s_f = 1;
        s_e = 1;
        m_cnt = m_cnt + 1;
      end
      m_fst = s_f || (m_fst && !sclr[0]);
      m_est = s_e || (m_est && !sclr[1]);
      m_nz  = (m_cnt != 0);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4 hold_o vs model", int'(hold), m_hold);
      chk("R6 nz_o vs model", int'(nz), int'(m_nz));
      chk("R7 first_stk_o vs model", int'(fst), int'(m_fst));
      chk("R8 evt_stk_o vs model", int'(est), int'(m_est));
    end
  end

  task automatic tick(input bit e, input bit u, input logic [1:0] c);
    evt = e; upd = u; sclr = c;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 hold_o reset", int'(hold), 0);
    chk("R1 nz_o reset", int'(nz), 0);
    chk("R1 stickies reset", int'({fst, est}), 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    tick(0, 0, 2'b00);

    // R2: five spaced events counted
    for (int i = 0; i < 10; i++) tick(i % 2 == 0, 0, 2'b00);
    chk("R6 nz_o high with count", int'(nz), 1);
    tick(0, 1, 2'b00);
    chk("R2 hold after five events", int'(hold), 5);
    chk("R6 nz_o low after clear", int'(nz), 0);
    tick(0, 0, 2'b00);

    // R4 / R5: held request, coincident event
    tick(1, 1, 2'b00);
    chk("R4 hold after empty interval", int'(hold), 0);
    for (int i = 0; i < 3; i++) tick(1, 1, 2'b00);
    chk("R4 hold steady while request stays high", int'(hold), 0);
    tick(0, 0, 2'b00);
    tick(0, 1, 2'b00);
    chk("R5 coincident event kept", int'(hold), 4);
    tick(0, 0, 2'b00);
    tick(0, 1, 2'b00);
    chk("R5 clear without event", int'(hold), 0);
    tick(0, 0, 2'b00);

    // R9 / R7 / R8: write-one-to-clear
    chk("R7 first sticky before clear", int'(fst), 1);
    tick(0, 0, 2'b01);
    chk("R9 bit0 cleared", int'(fst), 0);
    chk("R9 bit1 untouched", int'(est), 1);
    tick(1, 0, 2'b10);
    chk("R9 set wins over clear", int'(est), 1);
    chk("R7 first sticky from zero", int'(fst), 1);
    tick(0, 0, 2'b11);
    chk("R9 both cleared", int'({fst, est}), 0);
    tick(1, 0, 2'b00);
    chk("R7 no set on nonzero count", int'(fst), 0);
    chk("R8 set on counted event", int'(est), 1);
    tick(0, 1, 2'b00);
    chk("R2 hold after two events", int'(hold), 2);
    tick(0, 0, 2'b00);

    // R3 / R8: saturation
    for (int i = 0; i < MAXV + 5; i++) tick(1, 0, 2'b00);
    tick(0, 0, 2'b10);
    chk("R9 evt sticky cleared", int'(est), 0);
    tick(1, 0, 2'b00);
    chk("R8 no set when saturated", int'(est), 0);
    chk("R6 nz_o at saturation", int'(nz), 1);
    tick(0, 1, 2'b00);
    chk("R3 saturated value", int'(hold), MAXV);
    tick(0, 0, 2'b00);
    tick(0, 0, 2'b00);

    finish_run();
  end
endmodule